// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the in-flight instructions of an out-of-order core in a circular buffer, from the cycle they are dispatched until the cycle they retire. Each dispatched instruction takes the slot at the tail. The slot number is returned to the front end as the instruction's destination tag. Execution units later broadcast results on a result bus, keyed by that tag. The slot then holds the value speculatively and can serve it as an operand to younger instructions through a tag lookup port.

Retirement is strictly in program order. Only the oldest slot may retire, and only once its result has arrived. A register-producing instruction retires through a register-file write strobe. A store retires through a store strobe that carries the address and data captured at completion. A branch retires with no strobe. If the branch was mispredicted, the buffer drops every younger slot in that same cycle.

The design accepts at most one dispatch and one retirement per cycle. The depth is a parameter.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, `look_hit` is 0, and `rf_we`, `st_we` and `flush_out` are 0.
- R2: An accepted dispatch takes tag `disp_tag`, and the next tag is one higher modulo DEPTH. `disp_ready` is 0 while DEPTH slots are occupied, and `disp_tag` is unchanged in any cycle with no dispatch and no flush.
- R3: A result-bus write (`cdb_valid`) to an occupied tag stores the value, address and mispredict flag, and marks the slot ready from the next cycle.
- R4: `look_hit` is 1 and `look_value` carries the stored value only when the looked-up slot is occupied and ready. For an occupied slot that is not ready, or a free slot, `look_hit` is 0.
- R5: Only the oldest slot retires, one per cycle, in the cycle its ready flag is visible. Younger slots that are already ready wait behind an oldest slot that is not ready.
- R6: Kind encoding on `disp_kind` is 0 = ALU, 1 = LOAD, 2 = STORE, 3 = BRANCH. An ALU or LOAD retirement raises `rf_we`, with `rf_waddr` set to the dispatched destination and `rf_wdata` set to the result.
- R7: A STORE retirement raises `st_we`, with `st_addr` and `st_data` set to the address and value from its completion, and leaves `rf_we` low. `rf_we` and `st_we` are never high together.
- R8: A BRANCH retires with no strobe. If its mispredict flag is set, `flush_out` is 1 in its retirement cycle. From the next cycle no younger slot exists: lookups miss, nothing retires, and `disp_tag` is the branch tag plus one.
- R9: In the flush cycle `disp_ready` is 0, so no dispatch is accepted, and result-bus writes in that cycle are discarded.
- R10: A dispatch and a retirement in the same cycle leave the occupancy unchanged. Both tag pointers wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Instruction kind (0 ALU, 1 LOAD, 2 STORE, 3 BRANCH) |
| disp_dest | input | REG_W | Destination register index |
| disp_ready | output | 1 | A slot is free and no flush is in progress |
| disp_tag | output | TAG_W | Tag given to the dispatched instruction |
| cdb_valid | input | 1 | Result bus write |
| cdb_tag | input | TAG_W | Tag of the completing instruction |
| cdb_value | input | DATA_W | Result value, or store data |
| cdb_addr | input | DATA_W | Store address |
| cdb_mispred | input | 1 | Branch outcome was mispredicted |
| look_tag | input | TAG_W | Tag for the operand lookup |
| look_hit | output | 1 | Looked-up slot is occupied and ready |
| look_value | output | DATA_W | Value held in the looked-up slot |
| rf_we | output | 1 | Register-file write at retirement |
| rf_waddr | output | REG_W | Register index to write |
| rf_wdata | output | DATA_W | Register value to write |
| st_we | output | 1 | Store retirement strobe |
| st_addr | output | DATA_W | Store address |
| st_data | output | DATA_W | Store data |
| flush_out | output | 1 | Mispredicted branch retiring; younger slots discarded |

## Verification
The hardest case to reach from the ports is a mispredicted branch at the head that has younger slots behind it which are already complete. Those slots would retire at once if the flush failed to drop them. The stimulus dispatches the branch and two younger instructions, completes the younger two first, and then completes the branch with the mispredict flag. In that same flush cycle it also drives a dispatch and a result-bus write. It then probes the dropped tags through the lookup port and re-allocates the first of them to check that no stale ready state is left behind. A second sequence fills the buffer and completes the slots in reverse order, so that the retirement order cannot follow the completion order.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_LOAD   = 2'd1,
    K_STORE  = 2'd2,
    K_BRANCH = 2'd3
  } rob_kind_e;

  // Kinds whose retirement writes the register file.
  function automatic logic kind_writes_reg(rob_kind_e k);
    return (k == K_ALU) || (k == K_LOAD);
  endfunction

  function automatic logic kind_is_store(rob_kind_e k);
    return k == K_STORE;
  endfunction

  function automatic logic kind_is_branch(rob_kind_e k);
    return k == K_BRANCH;
  endfunction

endpackage

// File: rtl/rob_ring_ctrl.sv
module rob_ring_ctrl #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_fire,
  input  logic             commit_fire,
  input  logic             flush_now,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] occ,
  output logic             full
);

  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  function automatic logic [TAG_W-1:0] ring_bump(logic [TAG_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] occ_step(logic [CNT_W-1:0] c, logic up, logic dn);
    return c + CNT_W'(up) - CNT_W'(dn);
  endfunction

  assign full = (occ == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (flush_now) begin
      // the mispredicted branch retires, and the tail snaps back to the new head
      head <= ring_bump(head);
      tail <= ring_bump(head);
      occ  <= '0;
    end else begin
      if (commit_fire) head <= ring_bump(head);
      if (disp_fire)   tail <= ring_bump(tail);
      occ <= occ_step(occ, disp_fire, commit_fire);
    end
  end

endmodule

// File: rtl/rob_slot_array.sv
module rob_slot_array
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              wb_fire,
  input  logic [TAG_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_value,
  input  logic [DATA_W-1:0] wb_addr,
  input  logic              wb_mispred,
  input  logic              retire_fire,
  input  logic              flush_now,
  input  logic [TAG_W-1:0]  hd_idx,
  input  logic [TAG_W-1:0]  lk_idx,
  output logic              hd_valid,
  output logic              hd_ready,
  output rob_kind_e         hd_kind,
  output logic [REG_W-1:0]  hd_dest,
  output logic [DATA_W-1:0] hd_value,
  output logic [DATA_W-1:0] hd_addr,
  output logic              hd_mispred,
  output logic              lk_valid,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value
);

  logic              s_valid   [DEPTH];
  logic              s_ready   [DEPTH];
  logic              s_mispred [DEPTH];
  rob_kind_e         s_kind    [DEPTH];
  logic [REG_W-1:0]  s_dest    [DEPTH];
  logic [DATA_W-1:0] s_value   [DEPTH];
  logic [DATA_W-1:0] s_addr    [DEPTH];

  // per-slot select decode
  logic [DEPTH-1:0] sel_alloc, sel_wb, sel_retire;

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    localparam logic [TAG_W-1:0] IDX = TAG_W'(i);
    assign sel_alloc[i]  = alloc_fire  && (alloc_idx == IDX);
    assign sel_wb[i]     = wb_fire     && (wb_idx == IDX);
    assign sel_retire[i] = retire_fire && (hd_idx == IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        s_valid[i]   <= 1'b0;
        s_ready[i]   <= 1'b0;
        s_mispred[i] <= 1'b0;
        s_kind[i]    <= K_ALU;
        s_dest[i]    <= '0;
        s_value[i]   <= '0;
        s_addr[i]    <= '0;
      end
    end else if (flush_now) begin
      for (int i = 0; i < DEPTH; i++) begin
        s_valid[i]   <= 1'b0;
        s_ready[i]   <= 1'b0;
        s_mispred[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sel_alloc[i]) begin
          s_valid[i]   <= 1'b1;
          s_ready[i]   <= 1'b0;
          s_mispred[i] <= 1'b0;
          s_kind[i]    <= alloc_kind;
          s_dest[i]    <= alloc_dest;
        end else if (sel_retire[i]) begin
          s_valid[i] <= 1'b0;
          s_ready[i] <= 1'b0;
        end
        // a write to a free slot is dropped
        if (sel_wb[i] && s_valid[i]) begin
          s_ready[i]   <= 1'b1;
          s_value[i]   <= wb_value;
          s_addr[i]    <= wb_addr;
          s_mispred[i] <= wb_mispred;
        end
      end
    end
  end

  // oldest-slot read port
  assign hd_valid   = s_valid[hd_idx];
  assign hd_ready   = s_ready[hd_idx];
  assign hd_kind    = s_kind[hd_idx];
  assign hd_dest    = s_dest[hd_idx];
  assign hd_value   = s_value[hd_idx];
  assign hd_addr    = s_addr[hd_idx];
  assign hd_mispred = s_mispred[hd_idx];

  // operand lookup read port
  assign lk_valid = s_valid[lk_idx];
  assign lk_ready = s_ready[lk_idx];
  assign lk_value = s_value[lk_idx];

endmodule

// File: rtl/rob_retire_dec.sv
module rob_retire_dec
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              hd_valid,
  input  logic              hd_ready,
  input  rob_kind_e         hd_kind,
  input  logic [REG_W-1:0]  hd_dest,
  input  logic [DATA_W-1:0] hd_value,
  input  logic [DATA_W-1:0] hd_addr,
  input  logic              hd_mispred,
  output logic              commit_fire,
  output logic              flush_now,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              st_we,
  output logic [DATA_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data
);

  always_comb begin
    commit_fire = hd_valid && hd_ready;
    rf_we       = commit_fire && kind_writes_reg(hd_kind);
    st_we       = commit_fire && kind_is_store(hd_kind);
    flush_now   = commit_fire && kind_is_branch(hd_kind) && hd_mispred;
    rf_waddr    = hd_dest;
    rf_wdata    = hd_value;
    st_addr     = hd_addr;
    st_data     = hd_value;
  end

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [1:0]        disp_kind,
  input  logic [REG_W-1:0]  disp_dest,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic [DATA_W-1:0] cdb_addr,
  input  logic              cdb_mispred,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_value,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              st_we,
  output logic [DATA_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              flush_out
);

  // named internal events, also watched by the checker
  logic             disp_fire;
  logic             cdb_fire;
  logic             commit_fire;
  logic             flush_now;
  logic             full;
  logic [TAG_W-1:0] head;
  logic [TAG_W-1:0] tail;
  logic [CNT_W-1:0] occ;

  logic              hd_valid, hd_ready, hd_mispred;
  rob_kind_e         hd_kind;
  logic [REG_W-1:0]  hd_dest;
  logic [DATA_W-1:0] hd_value, hd_addr;
  logic              lk_valid, lk_ready;

  assign disp_ready = !full && !flush_now;
  assign disp_fire  = disp_valid && disp_ready;
  assign cdb_fire   = cdb_valid && !flush_now;
  assign disp_tag   = tail;
  assign look_hit   = lk_valid && lk_ready;
  assign flush_out  = flush_now;

  rob_ring_ctrl #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) ring_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_fire   (disp_fire),
    .commit_fire (commit_fire),
    .flush_now   (flush_now),
    .head        (head),
    .tail        (tail),
    .occ         (occ),
    .full        (full)
  );

  rob_slot_array #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .REG_W(REG_W)
  ) slots_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (disp_fire),
    .alloc_idx   (tail),
    .alloc_kind  (rob_kind_e'(disp_kind)),
    .alloc_dest  (disp_dest),
    .wb_fire     (cdb_fire),
    .wb_idx      (cdb_tag),
    .wb_value    (cdb_value),
    .wb_addr     (cdb_addr),
    .wb_mispred  (cdb_mispred),
    .retire_fire (commit_fire),
    .flush_now   (flush_now),
    .hd_idx      (head),
    .lk_idx      (look_tag),
    .hd_valid    (hd_valid),
    .hd_ready    (hd_ready),
    .hd_kind     (hd_kind),
    .hd_dest     (hd_dest),
    .hd_value    (hd_value),
    .hd_addr     (hd_addr),
    .hd_mispred  (hd_mispred),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .lk_value    (look_value)
  );

  rob_retire_dec #(
    .DATA_W(DATA_W), .REG_W(REG_W)
  ) retire_i (
    .hd_valid    (hd_valid),
    .hd_ready    (hd_ready),
    .hd_kind     (hd_kind),
    .hd_dest     (hd_dest),
    .hd_value    (hd_value),
    .hd_addr     (hd_addr),
    .hd_mispred  (hd_mispred),
    .commit_fire (commit_fire),
    .flush_now   (flush_now),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .rf_wdata    (rf_wdata),
    .st_we       (st_we),
    .st_addr     (st_addr),
    .st_data     (st_data)
  );

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_fire,
  input logic             commit_fire,
  input logic             flush_now,
  input logic [CNT_W-1:0] occ,
  input logic [TAG_W-1:0] disp_tag,
  input logic             rf_we,
  input logic             st_we
);

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_tag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_fire && !flush_now) |=> $stable(disp_tag));

  assert_commit_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (occ != '0));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && st_we));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (occ == '0));

  assert_occ_balance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_now && disp_fire && commit_fire) |=> (occ == $past(occ)));

  assert_occ_grow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_now && disp_fire && !commit_fire) |=> (occ == $past(occ) + 1'b1));

endmodule

bind rob_core rob_core_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_fire   (disp_fire),
  .commit_fire (commit_fire),
  .flush_now   (flush_now),
  .occ         (occ),
  .disp_tag    (disp_tag),
  .rf_we       (rf_we),
  .st_we       (st_we)
);

// File: tb/rob_core_tb.sv
module rob_core_tb_top;

  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int REG_W  = 5;
  localparam int TAG_W  = 3;

  // row: kind[70:69] dest[68:64] value[63:32] addr[31:0]
  localparam logic [70:0] TBL [8] = '{
    {2'd0, 5'd3,  32'h0000_1111, 32'h0000_0000},
    {2'd1, 5'd7,  32'h2222_0002, 32'h0000_0000},
    {2'd2, 5'd0,  32'hDEAD_0003, 32'h0000_0100},
    {2'd3, 5'd0,  32'h0000_0000, 32'h0000_0000},
    {2'd0, 5'd31, 32'h4444_0004, 32'h0000_0000},
    {2'd2, 5'd0,  32'h5555_0005, 32'h0000_0200},
    {2'd1, 5'd12, 32'h6666_0006, 32'h0000_0000},
    {2'd0, 5'd1,  32'h7777_0007, 32'h0000_0000}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              disp_valid = 1'b0;
  logic [1:0]        disp_kind = '0;
  logic [REG_W-1:0]  disp_dest = '0;
  logic              disp_ready;
  logic [TAG_W-1:0]  disp_tag;
  logic              cdb_valid = 1'b0;
  logic [TAG_W-1:0]  cdb_tag = '0;
  logic [DATA_W-1:0] cdb_value = '0;
  logic [DATA_W-1:0] cdb_addr = '0;
  logic              cdb_mispred = 1'b0;
  logic [TAG_W-1:0]  look_tag = '0;
  logic              look_hit;
  logic [DATA_W-1:0] look_value;
  logic              rf_we;
  logic [REG_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic              st_we;
  logic [DATA_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data;
  logic              flush_out;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_dest(disp_dest),
    .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_addr(cdb_addr), .cdb_mispred(cdb_mispred),
    .look_tag(look_tag), .look_hit(look_hit), .look_value(look_value),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .flush_out(flush_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    nxt();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "disp_ready", 64'(disp_ready), 64'd1);
    chk("R1", "disp_tag", 64'(disp_tag), 64'd0);
    chk("R1", "look_hit", 64'(look_hit), 64'd0);
    chk("R1", "strobes", {61'd0, rf_we, st_we, flush_out}, 64'd0);

    // table: fill, complete in reverse, retire in order
    for (int i = 0; i < DEPTH; i++) begin
      disp_valid = 1'b1;
      disp_kind  = TBL[i][70:69];
      disp_dest  = TBL[i][68:64];
      #1;
      chk("R2", "dispatch tag", 64'(disp_tag), 64'(i));
      chk("R2", "ready before full", 64'(disp_ready), 64'd1);
      nxt();
    end
    disp_valid = 1'b0;
    look_tag   = 3'd3;
    #1;
    chk("R2", "ready when full", 64'(disp_ready), 64'd0);
    chk("R4", "lookup not ready", 64'(look_hit), 64'd0);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      cdb_valid = 1'b1;
      cdb_tag   = TAG_W'(i);
      cdb_value = TBL[i][63:32];
      cdb_addr  = TBL[i][31:0];
      nxt();
      if (i != 0) begin
        #1;
        chk("R5", "no retire behind unready head", {62'd0, rf_we, st_we}, 64'd0);
      end
      if (i == 3) begin
        chk("R3", "ready after completion", 64'(look_hit), 64'd1);
        chk("R4", "lookup value", 64'(look_value), 64'(TBL[3][63:32]));
      end
    end
    cdb_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      if (TBL[i][70:69] == 2'd0 || TBL[i][70:69] == 2'd1) begin
        chk("R6", "rf_we", 64'(rf_we), 64'd1);
        chk("R6", "rf_waddr", 64'(rf_waddr), 64'(TBL[i][68:64]));
        chk("R6", "rf_wdata", 64'(rf_wdata), 64'(TBL[i][63:32]));
      end else if (TBL[i][70:69] == 2'd2) begin
        chk("R7", "st_we/rf_we", {62'd0, st_we, rf_we}, 64'd2);
        chk("R7", "st_addr", 64'(st_addr), 64'(TBL[i][31:0]));
        chk("R7", "st_data", 64'(st_data), 64'(TBL[i][63:32]));
      end else begin
        chk("R8", "branch retire quiet", {61'd0, rf_we, st_we, flush_out}, 64'd0);
      end
      nxt();
    end
    #1;
    chk("R10", "tail wrapped", 64'(disp_tag), 64'd0);
    chk("R5", "drained", {62'd0, rf_we, st_we}, 64'd0);

    // R10 dispatch alongside retirement
    disp_valid = 1'b1; disp_kind = 2'd0; disp_dest = 5'd2;
    nxt();
    disp_kind = 2'd1; disp_dest = 5'd4;
    cdb_valid = 1'b1; cdb_tag = 3'd0; cdb_value = 32'hAAAA_0000; cdb_addr = '0;
    #1;
    chk("R10", "second tag", 64'(disp_tag), 64'd1);
    nxt();
    cdb_valid = 1'b0;
    disp_kind = 2'd2; disp_dest = 5'd0;
    #1;
    chk("R10", "retire with dispatch", 64'(rf_we), 64'd1);
    chk("R6", "rf_wdata A", 64'(rf_wdata), 64'h0000_0000_AAAA_0000);
    chk("R10", "third tag", 64'(disp_tag), 64'd2);
    nxt();
    disp_valid = 1'b0;
    cdb_valid = 1'b1; cdb_tag = 3'd2; cdb_value = 32'h0000_00CC; cdb_addr = 32'h300;
    #1;
    chk("R5", "head B unready", {62'd0, rf_we, st_we}, 64'd0);
    nxt();
    cdb_tag = 3'd1; cdb_value = 32'h0000_00BB; cdb_addr = '0;
    #1;
    chk("R5", "younger C waits", {62'd0, rf_we, st_we}, 64'd0);
    nxt();
    cdb_valid = 1'b0;
    #1;
    chk("R5", "B retires", {59'd0, rf_we, rf_waddr}, {59'd0, 1'b1, 5'd4});
    nxt();
    #1;
    chk("R7", "C store", {31'd0, st_we, st_addr}, {31'd0, 1'b1, 32'h300});
    nxt();
    #1;
    chk("R10", "tag after run", 64'(disp_tag), 64'd3);

    // R8/R9 mispredicted branch with completed younger slots
    disp_valid = 1'b1; disp_kind = 2'd3; disp_dest = 5'd0;
    nxt();
    disp_kind = 2'd0; disp_dest = 5'd6;
    nxt();
    disp_kind = 2'd2;
    nxt();
    disp_valid = 1'b0;
    cdb_valid = 1'b1; cdb_tag = 3'd4; cdb_value = 32'h1234_5678; cdb_addr = '0;
    nxt();
    cdb_tag = 3'd5; cdb_value = 32'h0000_0055; cdb_addr = 32'h500;
    nxt();
    cdb_tag = 3'd3; cdb_value = '0; cdb_mispred = 1'b1;
    #1;
    chk("R5", "branch not ready yet", {62'd0, rf_we, st_we}, 64'd0);
    nxt();
    cdb_tag = 3'd4; cdb_value = 32'hBAD0_BAD0; cdb_mispred = 1'b0;
    disp_valid = 1'b1; disp_kind = 2'd0; disp_dest = 5'd9;
    #1;
    chk("R8", "flush_out", 64'(flush_out), 64'd1);
    chk("R8", "no strobe on branch", {62'd0, rf_we, st_we}, 64'd0);
    chk("R9", "no dispatch in flush", 64'(disp_ready), 64'd0);
    nxt();
    cdb_valid = 1'b0; disp_valid = 1'b0;
    look_tag = 3'd4;
    #1;
    chk("R8", "younger dropped", 64'(look_hit), 64'd0);
    chk("R8", "nothing retires", {61'd0, rf_we, st_we, flush_out}, 64'd0);
    chk("R8", "tag after flush", 64'(disp_tag), 64'd4);
    chk("R8", "ready after flush", 64'(disp_ready), 64'd1);
    look_tag = 3'd5;
    #1;
    chk("R8", "store dropped", 64'(look_hit), 64'd0);
    disp_valid = 1'b1;
    nxt();
    disp_valid = 1'b0;
    look_tag = 3'd4;
    #1;
    chk("R9", "reused slot not ready", 64'(look_hit), 64'd0);
    cdb_valid = 1'b1; cdb_tag = 3'd4; cdb_value = 32'h0000_0909;
    nxt();
    cdb_valid = 1'b0;
    #1;
    chk("R6", "post-flush retire", {58'd0, rf_we, rf_waddr}, {58'd0, 1'b1, 5'd9});
    chk("R3", "post-flush value", 64'(rf_wdata), 64'h909);
    nxt();
    finish_run();
  end

endmodule